// File: doc/BRIEF.md
# Crossing History Buffer with Lookback Capture

This block keeps a rolling history of per-crossing energy samples for two input channels and, on request, pulls out the values recorded a chosen number of crossings earlier. Each crossing occupies one period of a phase select signal. Every sample arrives as a 9-bit value on an input strobe. The block saturates it to 8 bits and stores it in one of four 32-entry memories: channel A or B, each with an EM side and a total side. A 5-bit write pointer moves forward once per crossing.

When the upstream logic asserts the capture request for two whole select periods, the block switches its registered memory address from the write pointer to the pointer minus a lookback distance. During the second period it latches all four stored values into capture registers. These registers are presented as one 16-bit word per channel, and a one-cycle done pulse marks the update. Memory writes stop while the address register may hold a read address, so a capture never corrupts the history.

The whole block runs on one clock. The select level and single-cycle strobes stand in for the level-sensitive timing of an asynchronous memory.

Top module: `xhist_buf`

## Requirements
- R1: Each stored sample equals the 9-bit input with bit 8 ORed into each of bits 7..0, so inputs of 256 to 511 are stored as 255 and inputs of 0 to 255 are stored unchanged.
- R2: A sample presented on a strobe while `tick_phase` is high is the EM value of the current period. A sample presented on a strobe while `tick_phase` is low is the total value of the following period. Each output word is {EM[15:8], total[7:0]}.
- R3: The write pointer starts at 0, advances by one at every rising edge of `tick_phase`, and wraps from 31 to 0. The total for a period is written on that period's high-phase strobe and the EM value on its low-phase strobe, both at the slot equal to the pointer during that period.
- R4: On the second consecutive capture period, the captured values come from slot (P − L) mod 32. Here P is the pointer during that period and L is the lookback latched for the capture.
- R5: The capture registers load only on the low-phase strobe of the second consecutive period with `capture` high. A capture held for a single period loads nothing, and the words hold their value at all other times.
- R6: No memory write happens in a period with `capture` high, nor in the period right after a capture period.
- R7: `lookback` is sampled only while no capture is active. Changes made after the first capture period has begun have no effect on that capture.
- R8: `capture_done` is high for exactly one cycle: the first cycle in which the newly loaded words are visible.
- R9: After synchronous reset, both words and `capture_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_phase | input | 1 | Phase select; rising edge ends one crossing period |
| strobe | input | 1 | Single-cycle sample/write strobe, one per phase half |
| capture | input | 1 | Capture request, changes only with a rising `tick_phase` |
| lookback | input | 5 | Lookback distance in crossings |
| sample_a | input | 9 | Channel A sample |
| sample_b | input | 9 | Channel B sample |
| word_a | output | 16 | Captured channel A {EM, total} |
| word_b | output | 16 | Captured channel B {EM, total} |
| capture_done | output | 1 | One-cycle pulse when new words appear |

## Verification
The history is first filled past one full pointer wrap with per-crossing values. These values are arithmetic functions of the crossing number, with forced 255, 256 and 511 inputs, so saturated and unsaturated slots appear in both channels and both halves of the crossing. A capture is then made at every lookback distance from 0 to 31. Distances 0 and 1 hit slots whose writes were suppressed and so must return data one wrap old, which separates write suppression from address arithmetic. Distances 2 and above separate the pointer-minus-lookback address from off-by-one variants. Each capture also drives a junk lookback value mid-capture, and a final single-period capture must load nothing, which separates the two-period rule from a one-period load.

// File: rtl/xhist_pkg.sv
package xhist_pkg;
  typedef enum logic { KIND_TOT = 1'b0, KIND_EM = 1'b1 } mem_kind_e;
  localparam int NUM_CH    = 2;
  localparam int NUM_KINDS = 2;
endpackage

// File: rtl/xhist_pack.sv
module xhist_pack #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [IN_W-1:0]  sample_in,
  output logic [OUT_W-1:0] stage_out
);
  logic             over;
  logic [OUT_W-1:0] sat;

  assign over = |sample_in[IN_W-1:OUT_W];
  assign sat  = sample_in[OUT_W-1:0] | {OUT_W{over}};

  always_ff @(posedge clk) begin
    if (rst) stage_out <= '0;
    else if (strobe) stage_out <= sat;
  end
endmodule

// File: rtl/xhist_addr.sv
module xhist_addr #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_phase,
  input  logic          capture,
  input  logic [AW-1:0] lookback,
  output logic          rise,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] lb_q,
  output logic          cap_q,
  output logic          rd_phase
);
  logic          phase_q;
  logic [AW-1:0] wr_next;
  logic [AW-1:0] rd_next;

  assign rise    = tick_phase && !phase_q;
  assign wr_next = wptr + AW'(1);
  assign rd_next = wr_next - lb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      wptr     <= '0;
      addr_q   <= '0;
      lb_q     <= '0;
      cap_q    <= 1'b0;
      rd_phase <= 1'b0;
    end else begin
      phase_q <= tick_phase;
      if (!cap_q) lb_q <= lookback;
      if (rise) begin
        wptr     <= wr_next;
        cap_q    <= capture;
        rd_phase <= cap_q;
        addr_q   <= cap_q ? rd_next : wr_next;
      end
    end
  end
endmodule

// File: rtl/xhist_ram.sv
module xhist_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/xhist_buf.sv
module xhist_buf #(
  parameter int IN_W  = 9,
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_phase,
  input  logic            strobe,
  input  logic            capture,
  input  logic [AW-1:0]   lookback,
  input  logic [IN_W-1:0] sample_a,
  input  logic [IN_W-1:0] sample_b,
  output logic [2*DW-1:0] word_a,
  output logic [2*DW-1:0] word_b,
  output logic            capture_done
);
  import xhist_pkg::*;

  logic            rise;
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   lb_q;
  logic            cap_q;
  logic            rd_phase;
  logic            wr_ok;
  logic            we_tot;
  logic            we_em;
  logic            wr_any;
  logic            load;
  logic [IN_W-1:0] samp  [NUM_CH];
  logic [DW-1:0]   stage [NUM_CH];
  logic [DW-1:0]   rdat  [NUM_CH][NUM_KINDS];
  logic [2*DW-1:0] word  [NUM_CH];

  assign samp[0] = sample_a;
  assign samp[1] = sample_b;

  xhist_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .tick_phase(tick_phase), .capture(capture),
    .lookback(lookback), .rise(rise), .wptr(wptr), .addr_q(addr_q),
    .lb_q(lb_q), .cap_q(cap_q), .rd_phase(rd_phase)
  );

  assign wr_ok  = !cap_q && !rd_phase;
  assign we_tot = strobe && tick_phase && wr_ok;
  assign we_em  = strobe && !tick_phase && wr_ok;
  assign wr_any = we_tot || we_em;
  assign load   = strobe && !tick_phase && cap_q && rd_phase;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xhist_pack #(.IN_W(IN_W), .OUT_W(DW)) u_pack (
      .clk(clk), .rst(rst), .strobe(strobe),
      .sample_in(samp[c]), .stage_out(stage[c])
    );
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      xhist_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk),
        .we((k == int'(KIND_EM)) ? we_em : we_tot),
        .addr(addr_q), .wdata(stage[c]), .rdata(rdat[c][k])
      );
    end
    always_ff @(posedge clk) begin
      if (rst) word[c] <= '0;
      else if (load) word[c] <= {rdat[c][int'(KIND_EM)], rdat[c][int'(KIND_TOT)]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) capture_done <= 1'b0;
    else capture_done <= load;
  end

  assign word_a = word[0];
  assign word_b = word[1];
endmodule

// File: rtl/xhist_chk.sv
module xhist_chk #(
  parameter int AW = 5,
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rise,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] addr_q,
  input logic [AW-1:0] lb_q,
  input logic          cap_q,
  input logic          rd_phase,
  input logic          wr_any,
  input logic [WW-1:0] word_a,
  input logic [WW-1:0] word_b,
  input logic          capture_done
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    rise |=> wptr == AW'($past(wptr) + AW'(1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(wptr)); // R3
  AST_ADDR_WR: assert property (@(posedge clk) disable iff (rst)
    (rise && !cap_q) |=> addr_q == wptr); // R3
  AST_ADDR_RD: assert property (@(posedge clk) disable iff (rst)
    (rise && cap_q) |=> addr_q == AW'(wptr - lb_q)); // R4
  AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cap_q || rd_phase) |-> !wr_any); // R6
  AST_LB_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cap_q |=> $stable(lb_q)); // R7
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture_done |-> ($stable(word_a) && $stable(word_b))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    capture_done |=> !capture_done); // R8
endmodule

bind xhist_buf xhist_chk #(.AW(AW), .WW(2*DW)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .wptr(wptr), .addr_q(addr_q),
  .lb_q(lb_q), .cap_q(cap_q), .rd_phase(rd_phase), .wr_any(wr_any),
  .word_a(word_a), .word_b(word_b), .capture_done(capture_done)
);

// File: tb/sim_xhist_buf.sv
module sim_xhist_buf;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_phase = 1'b0;
  logic       strobe = 1'b0;
  logic       capture = 1'b0;
  logic [4:0] lookback = '0;
  logic [8:0] sample_a = '0;
  logic [8:0] sample_b = '0;
  logic [15:0] word_a, word_b;
  logic       capture_done;

  int n_chk = 0;
  int n_err = 0;

  int         wp = 0;
  int         t = 0;
  bit         prev_cap = 0;
  logic [7:0] st_a = 0, st_b = 0;
  bit         ov_a = 0;
  logic [7:0] m_tot_a [32], m_em_a [32], m_tot_b [32], m_em_b [32];
  bit         m_ov_a [32];
  logic [15:0] exp_a = 0, exp_b = 0;

  always #2 clk = ~clk;

  xhist_buf u0 (
    .clk(clk), .rst(rst), .tick_phase(tick_phase), .strobe(strobe),
    .capture(capture), .lookback(lookback), .sample_a(sample_a),
    .sample_b(sample_b), .word_a(word_a), .word_b(word_b),
    .capture_done(capture_done)
  );

  function automatic logic [7:0] sat(input int v);
    return (v >= 256) ? 8'd255 : v[7:0];
  endfunction

  function automatic int em_a_of(input int k);
    if (k % 16 == 3) return 256;
    if (k % 16 == 4) return 255;
    if (k % 16 == 5) return 511;
    return (k * 37 + 5) % 512;
  endfunction
  function automatic int em_b_of(input int k);  return (k * 91 + 300) % 512; endfunction
  function automatic int tot_a_of(input int k); return (k * 53 + 11) % 512;  endfunction
  function automatic int tot_b_of(input int k); return (k * 17 + 400) % 512; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic period(input bit cap, input bit second, input int lb);
    bit    sup;
    int    a;
    string tag;
    @(negedge clk);
    tick_phase = 1'b1; strobe = 1'b0; capture = cap;
    if (cap && !second) lookback = lb[4:0];
    wp = (wp + 1) % 32;
    sup = cap || prev_cap;
    @(negedge clk);
    strobe = 1'b1;
    sample_a = em_a_of(t)[8:0]; sample_b = em_b_of(t)[8:0];
    if (!sup) begin m_tot_a[wp] = st_a; m_tot_b[wp] = st_b; m_ov_a[wp] = ov_a; end
    st_a = sat(em_a_of(t)); st_b = sat(em_b_of(t)); ov_a = em_a_of(t) >= 256;
    @(negedge clk);
    strobe = 1'b0;
    if (cap && !second) lookback = ~lb[4:0];
    @(negedge clk);
    @(negedge clk);
    tick_phase = 1'b0;
    @(negedge clk);
    strobe = 1'b1;
    sample_a = tot_a_of(t + 1)[8:0]; sample_b = tot_b_of(t + 1)[8:0];
    if (!sup) begin m_em_a[wp] = st_a; m_em_b[wp] = st_b; m_ov_a[wp] = m_ov_a[wp] | ov_a; end
    st_a = sat(tot_a_of(t + 1)); st_b = sat(tot_b_of(t + 1)); ov_a = tot_a_of(t + 1) >= 256;
    @(negedge clk);
    strobe = 1'b0;
    if (cap && second) begin
      a = ((wp - lb) % 32 + 32) % 32;
      exp_a = {m_em_a[a], m_tot_a[a]};
      exp_b = {m_em_b[a], m_tot_b[a]};
      if (lb <= 1) tag = "R6 R4";
      else if (m_ov_a[a]) tag = "R1 R4 R7";
      else tag = "R3 R4 R7";
      chk("R5 R8 done", capture_done, 1);
      chk(tag, word_a, exp_a);
      chk("R2 word_b", word_b, exp_b);
    end else begin
      chk("R5 no load", capture_done, 0);
      chk("R5 hold", word_a, exp_a);
    end
    @(negedge clk);
    if (cap && second) chk("R8 pulse end", capture_done, 0);
    prev_cap = cap;
    t++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 word_a", word_a, 0);
    chk("R9 word_b", word_b, 0);
    chk("R9 done", capture_done, 0);
    for (int i = 0; i < 40; i++) period(0, 0, 0);
    for (int l = 0; l < 32; l++) begin
      period(1, 0, l);
      period(1, 1, l);
      for (int g = 0; g < 3; g++) period(0, 0, 0);
    end
    period(1, 0, 7);
    period(0, 0, 0);
    period(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule